// File: doc/BRIEF.md
# Extended-to-Double Precision Narrowing Converter

This block narrows an 80-bit extended-precision floating-point value to a 64-bit IEEE double in one registered stage. An upstream classifier has already sorted the operand into a coarse kind (ordinary number, zero, special, empty slot) and, for specials, a subclass. The converter uses that classification to pick the conversion path. It does not inspect the bit pattern to work out what kind of value it holds.

Ordinary numbers are rebiased. The explicit integer bit is dropped and the top 52 fraction bits are kept. When the 11 discarded bits are not all zero, the result is rounded under a 2-bit rounding mode. Rounding treats the packed double as an integer and either keeps the truncated pattern or moves one step away from zero. Exponents outside the double's normal range saturate silently to the smallest or largest normal magnitude, never to infinity or a denormal. Zeros, infinities and NaNs map to fixed double encodings. A denormal operand goes through the ordinary-number path and raises a one-cycle indication.

Top module: `xdbl_convert`

## Requirements
- R1: Results appear one clock after the input is accepted. `out_valid` is high exactly one cycle after a cycle with `in_valid` high and a kind other than empty (3); an empty kind produces no output. Reset holds `out_valid` and `out_dnrm` low.
- R2: For an ordinary number (kind 0) whose unbiased exponent e = biased − 16383 lies in −1022..1023, the double exponent field is e + 1023 and the fraction is significand bits 62:11. When significand bits 10:0 are all zero, this truncated pattern is the exact result in every rounding mode. The output kind is 0 and the output subclass is 0.
- R3: If e < −1022, the result is {sign, exponent 0x001, fraction 0}. If e > 1023, the result is {sign, exponent 0x7FE, fraction all ones}. A saturated result is never rounded, and an ordinary-number result never has an all-ones exponent.
- R4: Rounding mode encoding is 0 nearest-even, 1 toward minus infinity, 2 toward plus infinity, 3 truncate. With inexact discarded bits:
  - mode 3 keeps the truncated pattern;
  - mode 1 adds 1 to the magnitude of negative values only;
  - mode 2 adds 1 to the magnitude of positive values only.
- R5: Nearest-even adds 1 to the magnitude when the discarded bits exceed 0x400. It keeps the truncated pattern below 0x400. On exactly 0x400 it picks whichever candidate has fraction bit 0 clear.
- R6: A rounding increment that carries the exponent to 0x7FF yields the largest finite magnitude with the original sign.
- R7: A zero operand (kind 1) yields a double zero with the input sign, output kind 1 and subclass 0.
- R8: Specials (kind 2) report output kind 2 with the input subclass. The subclass codes are 0 infinity, 1 quiet NaN, 2 signalling NaN, 3 indefinite, 4 denormal. The results are:
  - infinity gives {sign, 0x7FF, 0};
  - indefinite gives 0xFFF8_0000_0000_0000;
  - either NaN gives {sign, 0x7FF, significand bits 62:11}.
- R9: A denormal (kind 2, subclass 4) is converted by the ordinary-number rules and reported with output kind 0. `out_dnrm` is high in its result cycle and low for every other result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operand present this cycle |
| in_ext | input | 80 | Extended value: sign 79, exponent 78:64, significand 63:0 |
| in_tag | input | 2 | Operand kind from the classifier |
| in_sub | input | 3 | Special subclass from the classifier |
| rnd_mode | input | 2 | Rounding mode |
| out_valid | output | 1 | Result present |
| out_dbl | output | 64 | Packed double result |
| out_tag | output | 2 | Result kind |
| out_sub | output | 3 | Result subclass (specials only) |
| out_dnrm | output | 1 | Denormal operand seen for this result |

## Verification
Two functions can meet in one cycle: the rounding increment and the exponent carry it produces. This happens when the top fraction bits are all ones at the highest in-range exponent. In that case the increment must give way to saturation at the largest finite magnitude, not produce infinity.

The bench provokes this directly with both signs under the modes that round away from zero. It also aims its random draws at exponents within two of each saturation boundary, with all-ones fractions and tie-valued discarded bits. An independent integer model judges every result, and in-RTL assertions watch the carry and saturation events.

// File: rtl/xdbl_pkg.sv
package xdbl_pkg;
  localparam int XEXP_W  = 15;
  localparam int XSIG_W  = 64;
  localparam int XW      = 1 + XEXP_W + XSIG_W;
  localparam int DEXP_W  = 11;
  localparam int DFRAC_W = 52;
  localparam int DW      = 1 + DEXP_W + DFRAC_W;
  localparam int MAG_W   = DW - 1;
  localparam int DROP_W  = XSIG_W - 1 - DFRAC_W;
  localparam int XBIAS   = (1 << (XEXP_W - 1)) - 1;
  localparam int DBIAS   = (1 << (DEXP_W - 1)) - 1;

  localparam logic [MAG_W-1:0] MAX_MAG =
    {{(DEXP_W-1){1'b1}}, 1'b0, {DFRAC_W{1'b1}}};
  localparam logic [MAG_W-1:0] MIN_MAG =
    {{(DEXP_W-1){1'b0}}, 1'b1, {DFRAC_W{1'b0}}};
  localparam logic [DW-1:0] INDEF_PAT =
    {1'b1, {DEXP_W{1'b1}}, 1'b1, {(DFRAC_W-1){1'b0}}};

  typedef enum logic [1:0] {
    KIND_NUM = 2'd0, KIND_ZER = 2'd1, KIND_SPC = 2'd2, KIND_EMP = 2'd3
  } kind_e;

  typedef enum logic [2:0] {
    SUB_INF = 3'd0, SUB_QNAN = 3'd1, SUB_SNAN = 3'd2,
    SUB_INDEF = 3'd3, SUB_DNRM = 3'd4
  } sub_e;

  typedef enum logic [1:0] {
    RM_NEAR = 2'd0, RM_DOWN = 2'd1, RM_UP = 2'd2, RM_CHOP = 2'd3
  } rmode_e;

  typedef struct packed {
    logic [MAG_W-1:0] mag;
    logic             ovf;
  } step_t;

  // Decide whether the truncated magnitude must move one step away from zero.
  function automatic logic f_round_up(input logic [1:0] mode, input logic sgn,
                                      input logic [DROP_W-1:0] drop,
                                      input logic lsb);
    logic half_bit, tail;
    half_bit = drop[DROP_W-1];
    tail     = |drop[DROP_W-2:0];
    case (rmode_e'(mode))
      RM_NEAR: f_round_up = half_bit && (tail || lsb);
      RM_DOWN: f_round_up = sgn && (|drop);
      RM_UP:   f_round_up = !sgn && (|drop);
      default: f_round_up = 1'b0;
    endcase
  endfunction

  // Integer increment of a packed magnitude; a carry into an all-ones
  // exponent is clamped to the largest finite magnitude.
  function automatic step_t f_step_away(input logic [MAG_W-1:0] mag);
    step_t r;
    r.mag = mag + MAG_W'(1);
    r.ovf = &r.mag[MAG_W-1 -: DEXP_W];
    if (r.ovf) r.mag = MAX_MAG;
    return r;
  endfunction
endpackage

// File: rtl/xdbl_numeric.sv
module xdbl_numeric
  import xdbl_pkg::*;
(
  input  logic [XW-1:0] ext,
  input  logic [1:0]    mode,
  output logic [DW-1:0] res,
  output logic          sat_hi,
  output logic          sat_lo,
  output logic          inexact,
  output logic          step_up,
  output logic          step_ovf
);
  localparam int UE_W = XEXP_W + 2;
  localparam logic signed [UE_W-1:0] UE_MIN = UE_W'(1 - DBIAS);
  localparam logic signed [UE_W-1:0] UE_MAX = UE_W'(DBIAS);

  logic                     sgn;
  logic [XEXP_W-1:0]        bexp;
  logic [XSIG_W-1:0]        sig;
  logic signed [UE_W-1:0]   uexp;
  logic signed [UE_W-1:0]   dexp_full;
  logic [MAG_W-1:0]         trunc_mag;
  logic [DROP_W-1:0]        drop;
  step_t                    stepped;

  assign sgn  = ext[XW-1];
  assign bexp = ext[XW-2 -: XEXP_W];
  assign sig  = ext[XSIG_W-1:0];

  // Rebias through a signed intermediate wide enough for both biases.
  assign uexp      = $signed({2'b00, bexp}) - $signed(UE_W'(XBIAS));
  assign dexp_full = uexp + $signed(UE_W'(DBIAS));
  assign sat_lo    = uexp < UE_MIN;
  assign sat_hi    = uexp > UE_MAX;

  assign trunc_mag = {dexp_full[DEXP_W-1:0], sig[XSIG_W-2 -: DFRAC_W]};
  assign drop      = sig[DROP_W-1:0];
  assign inexact   = |drop;

  assign step_up  = !sat_hi && !sat_lo && inexact &&
                    f_round_up(mode, sgn, drop, trunc_mag[0]);
  assign stepped  = f_step_away(trunc_mag);
  assign step_ovf = step_up && stepped.ovf;

  always_comb begin
    if (sat_hi)       res = {sgn, MAX_MAG};
    else if (sat_lo)  res = {sgn, MIN_MAG};
    else if (step_up) res = {sgn, stepped.mag};
    else              res = {sgn, trunc_mag};
  end
endmodule

// File: rtl/xdbl_special.sv
module xdbl_special
  import xdbl_pkg::*;
(
  input  logic [XW-1:0] ext,
  input  logic [2:0]    sub,
  output logic [DW-1:0] res
);
  logic sgn;
  logic [DFRAC_W-1:0] frac;

  assign sgn  = ext[XW-1];
  assign frac = ext[XSIG_W-2 -: DFRAC_W];

  always_comb begin
    case (sub_e'(sub))
      SUB_INF:   res = {sgn, {DEXP_W{1'b1}}, {DFRAC_W{1'b0}}};
      SUB_INDEF: res = INDEF_PAT;
      default:   res = {sgn, {DEXP_W{1'b1}}, frac};
    endcase
  end
endmodule

// File: rtl/xdbl_convert.sv
module xdbl_convert
  import xdbl_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [79:0]   in_ext,
  input  logic [1:0]    in_tag,
  input  logic [2:0]    in_sub,
  input  logic [1:0]    rnd_mode,
  output logic          out_valid,
  output logic [63:0]   out_dbl,
  output logic [1:0]    out_tag,
  output logic [2:0]    out_sub,
  output logic          out_dnrm
);
  // Named events used by the checks below.
  logic num_sat_hi, num_sat_lo, num_inexact, num_step_up, num_step_ovf;
  logic is_dnrm, is_inf, is_zero, numeric_sel, accept;
  logic [DW-1:0] num_res, spc_res, nxt_dbl;
  logic [1:0] nxt_tag;
  logic [2:0] nxt_sub;

  assign is_dnrm     = (kind_e'(in_tag) == KIND_SPC) && (sub_e'(in_sub) == SUB_DNRM);
  assign is_inf      = (kind_e'(in_tag) == KIND_SPC) && (sub_e'(in_sub) == SUB_INF);
  assign is_zero     = (kind_e'(in_tag) == KIND_ZER);
  assign numeric_sel = (kind_e'(in_tag) == KIND_NUM) || is_dnrm;
  assign accept      = in_valid && (kind_e'(in_tag) != KIND_EMP);

  xdbl_numeric u_num (
    .ext(in_ext), .mode(rnd_mode), .res(num_res),
    .sat_hi(num_sat_hi), .sat_lo(num_sat_lo), .inexact(num_inexact),
    .step_up(num_step_up), .step_ovf(num_step_ovf)
  );

  xdbl_special u_spc (.ext(in_ext), .sub(in_sub), .res(spc_res));

  always_comb begin
    nxt_dbl = num_res;
    nxt_tag = KIND_NUM;
    nxt_sub = 3'd0;
    if (is_zero) begin
      nxt_dbl = {in_ext[XW-1], {MAG_W{1'b0}}};
      nxt_tag = KIND_ZER;
    end else if (!numeric_sel) begin
      nxt_dbl = spc_res;
      nxt_tag = KIND_SPC;
      nxt_sub = in_sub;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_dnrm  <= 1'b0;
      out_dbl   <= '0;
      out_tag   <= '0;
      out_sub   <= '0;
    end else begin
      out_valid <= accept;
      out_dnrm  <= accept && is_dnrm;
      if (accept) begin
        out_dbl <= nxt_dbl;
        out_tag <= nxt_tag;
        out_sub <= nxt_sub;
      end
    end
  end

  AST_EXACT_FRAC: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && numeric_sel && !num_sat_hi && !num_sat_lo && !num_inexact
    |=> out_dbl[DFRAC_W-1:0] == $past(in_ext[XSIG_W-2 -: DFRAC_W])); // R2
  AST_SAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && numeric_sel && num_sat_hi |=> out_dbl[MAG_W-1:0] == MAX_MAG); // R3
  AST_SAT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && numeric_sel && num_sat_lo |=> out_dbl[MAG_W-1:0] == MIN_MAG); // R3
  AST_NO_INF_NUM: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_tag == KIND_NUM |-> !(&out_dbl[MAG_W-1 -: DEXP_W])); // R3
  AST_CARRY_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && numeric_sel && num_step_ovf |=> out_dbl[MAG_W-1:0] == MAX_MAG); // R6
  AST_ZERO_MAG: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && is_zero |=> out_dbl[MAG_W-1:0] == '0 && out_tag == KIND_ZER); // R7
  AST_INF_PAT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && is_inf |=> out_dbl[MAG_W-1:0] == {{DEXP_W{1'b1}}, {DFRAC_W{1'b0}}}); // R8
  AST_DNRM_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    out_dnrm |-> out_valid && out_tag == KIND_NUM); // R9
endmodule

// File: tb/xdbl_convert_tb_top.sv
module xdbl_convert_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [79:0] in_ext = '0;
  logic [1:0]  in_tag = '0;
  logic [2:0]  in_sub = '0;
  logic [1:0]  rnd_mode = '0;
  logic        out_valid, out_dnrm;
  logic [63:0] out_dbl;
  logic [1:0]  out_tag;
  logic [2:0]  out_sub;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xdbl_convert dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ext(in_ext),
    .in_tag(in_tag), .in_sub(in_sub), .rnd_mode(rnd_mode),
    .out_valid(out_valid), .out_dbl(out_dbl), .out_tag(out_tag),
    .out_sub(out_sub), .out_dnrm(out_dnrm)
  );

  // Independent model of the ordinary-number path, using plain integers.
  function automatic logic [63:0] ref_num(input logic [79:0] x, input logic [1:0] md);
    int        ue;
    logic [62:0] mag;
    logic [10:0] lo;
    bit        up;
    ue  = int'(x[78:64]) - 16383;
    if (ue > 1023)  return {x[79], 11'h7fe, {52{1'b1}}};
    if (ue < -1022) return {x[79], 11'h001, 52'd0};
    mag = {11'(ue + 1023), x[62:11]};
    lo  = x[10:0];
    case (md)
      2'd0:    up = (lo > 11'h400) || (lo == 11'h400 && mag[0]);
      2'd1:    up = x[79] && (lo != 0);
      2'd2:    up = !x[79] && (lo != 0);
      default: up = 1'b0;
    endcase
    if (up) begin
      mag = mag + 63'd1;
      if (mag[62:52] == 11'h7ff) mag = {11'h7fe, {52{1'b1}}};
    end
    return {x[79], mag};
  endfunction

  task automatic apply(input string req, input logic [79:0] x, input logic [1:0] tg,
                       input logic [2:0] sb, input logic [1:0] md);
    logic [63:0] e_dbl;
    logic [1:0]  e_tag;
    logic [2:0]  e_sub;
    logic        e_vld, e_dn;
    e_vld = (tg != 2'd3);
    e_dn  = 1'b0;
    e_sub = 3'd0;
    e_tag = 2'd0;
    e_dbl = 64'd0;
    if (tg == 2'd0) e_dbl = ref_num(x, md);
    else if (tg == 2'd1) begin e_tag = 2'd1; e_dbl = {x[79], 63'd0}; end
    else if (tg == 2'd2 && sb == 3'd4) begin e_dn = 1'b1; e_dbl = ref_num(x, md); end
    else if (tg == 2'd2) begin
      e_tag = 2'd2;
      e_sub = sb;
      if (sb == 3'd0)      e_dbl = {x[79], 11'h7ff, 52'd0};
      else if (sb == 3'd3) e_dbl = 64'hFFF8_0000_0000_0000;
      else                 e_dbl = {x[79], 11'h7ff, x[62:11]};
    end
    @(negedge clk);
    in_valid = 1'b1; in_ext = x; in_tag = tg; in_sub = sb; rnd_mode = md;
    @(negedge clk);
    in_valid = 1'b0;
    n_chk++;
    if (out_valid !== e_vld || out_dnrm !== e_dn ||
        (e_vld && (out_dbl !== e_dbl || out_tag !== e_tag || out_sub !== e_sub))) begin
      n_bad++;
      $display("FAIL %s: got v=%0b dbl=%h tag=%0d sub=%0d dn=%0b exp v=%0b dbl=%h tag=%0d sub=%0d dn=%0b",
               req, out_valid, out_dbl, out_tag, out_sub, out_dnrm,
               e_vld, e_dbl, e_tag, e_sub, e_dn);
    end
  endtask

  function automatic logic [79:0] mk(input bit s, input int be, input logic [62:0] f);
    return {s, 15'(be), 1'b1, f};
  endfunction

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    n_chk++;  // R1 reset state
    if (out_valid !== 1'b0 || out_dnrm !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset: got v=%0b dn=%0b exp 0 0", out_valid, out_dnrm);
    end
    rst_n = 1'b1;

    // Directed corner cases
    apply("R1 empty", mk(0, 16383, 63'd5), 2'd3, 3'd0, 2'd0);
    apply("R2 exact one", mk(0, 16383, 63'd0), 2'd0, 3'd0, 2'd0);
    apply("R2 exact neg", mk(1, 16400, 63'h1234_5678_9ABC_D800), 2'd0, 3'd0, 2'd2);
    apply("R3 high", mk(0, 17407, 63'd0), 2'd0, 3'd0, 2'd2);
    apply("R3 low", mk(1, 15360, 63'h7ff), 2'd0, 3'd0, 2'd1);
    apply("R3 edge hi in", mk(1, 17406, 63'd0), 2'd0, 3'd0, 2'd0);
    apply("R3 edge lo in", mk(0, 15361, 63'd1), 2'd0, 3'd0, 2'd1);
    apply("R4 chop", mk(0, 16383, 63'h7ff), 2'd0, 3'd0, 2'd3);
    apply("R4 down pos", mk(0, 16383, 63'h7ff), 2'd0, 3'd0, 2'd1);
    apply("R4 down neg", mk(1, 16383, 63'h001), 2'd0, 3'd0, 2'd1);
    apply("R4 up pos", mk(0, 16383, 63'h001), 2'd0, 3'd0, 2'd2);
    apply("R4 up neg", mk(1, 16383, 63'h7ff), 2'd0, 3'd0, 2'd2);
    apply("R5 tie even", mk(0, 16383, 63'h400), 2'd0, 3'd0, 2'd0);
    apply("R5 tie odd", mk(0, 16383, 63'hC00), 2'd0, 3'd0, 2'd0);
    apply("R5 above", mk(1, 16383, 63'h401), 2'd0, 3'd0, 2'd0);
    apply("R5 below", mk(0, 16383, 63'h3ff), 2'd0, 3'd0, 2'd0);
    apply("R6 carry up", mk(0, 17406, {63{1'b1}}), 2'd0, 3'd0, 2'd2);
    apply("R6 carry down", mk(1, 17406, {63{1'b1}}), 2'd0, 3'd0, 2'd1);
    apply("R6 carry near", mk(0, 17406, {63{1'b1}}), 2'd0, 3'd0, 2'd0);
    apply("R7 zero neg", {1'b1, 79'd0}, 2'd1, 3'd0, 2'd2);
    apply("R8 inf", {1'b1, 15'h7fff, 1'b1, 63'd0}, 2'd2, 3'd0, 2'd0);
    apply("R8 indef", {1'b1, 15'h7fff, 2'b11, 62'd0}, 2'd2, 3'd3, 2'd0);
    apply("R8 qnan", {1'b0, 15'h7fff, 2'b11, 62'h0ABC_0000_1234_5678}, 2'd2, 3'd1, 2'd0);
    apply("R8 snan", {1'b1, 15'h7fff, 2'b10, 62'h1000_0000_0000_0000}, 2'd2, 3'd2, 2'd0);
    apply("R9 denorm", {1'b0, 15'd0, 1'b0, 63'h0000_0000_0000_0FFF}, 2'd2, 3'd4, 2'd2);
    apply("R9 after denorm", mk(0, 16383, 63'd0), 2'd0, 3'd0, 2'd0);

    // Constrained random mix
    for (int i = 0; i < 3000; i++) begin
      int          k, be;
      bit          s;
      logic [62:0] f;
      logic [1:0]  md;
      k  = $urandom_range(0, 11);
      s  = 1'($urandom_range(0, 1));
      md = 2'($urandom_range(0, 3));
      f  = {$urandom(), $urandom()};
      case ($urandom_range(0, 3))
        0: f[10:0] = 11'h400;
        1: f[10:0] = 11'h000;
        2: f[62:11] = {52{1'b1}};
        default: ;
      endcase
      case ($urandom_range(0, 3))
        0: be = 15361 + $urandom_range(0, 4) - 2;
        1: be = 17406 + $urandom_range(0, 4) - 2;
        2: be = $urandom_range(1, 32766);
        default: be = $urandom_range(15363, 17404);
      endcase
      if (k < 6)       apply("R2 R4 R5 random num", mk(s, be, f), 2'd0, 3'd0, md);
      else if (k == 6) apply("R7 random zero", {s, 79'd0}, 2'd1, 3'd0, md);
      else if (k < 9)  apply("R8 random special", {s, 15'h7fff, 1'b1, f}, 2'd2,
                             3'($urandom_range(0, 3)), md);
      else if (k == 9) apply("R9 random denorm", {s, 15'd0, 1'b0, f}, 2'd2, 3'd4, md);
      else if (k == 10) apply("R3 R6 random edge", mk(s, be, {{52{1'b1}}, f[10:0]}), 2'd0, 3'd0, md);
      else             apply("R1 random empty", mk(s, be, f), 2'd3, 3'd0, md);
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule